// File: doc/BRIEF.md
# Block Chaining Mode Unit

This unit sits in front of an external 128-bit block cipher core and turns it into a message engine. It applies one of four chaining modes (electronic codebook, cipher-block chaining, output feedback, cipher feedback) to a sequence of 128-bit blocks, in either the encrypt or the decrypt direction. It keeps the 128-bit chaining value, forms the core's input for each block, and combines the core's result with the data and the chaining value to produce the output block.

A message starts with a one-cycle start strobe that carries a control word and a byte length. Blocks then enter and leave over valid/ready handshakes. Each block is sent to the core through a request/response port that also says which key schedule the core must use. The chaining value is loaded by a strobe while the unit is idle. It stays visible afterwards, so a later message can continue the same chain. A done pulse with a fail flag reports how the message ended.

Top module: `blk_chain_unit`

## Requirements
- R1: Control word `cfg_ctrl_i`: bits 6:5 select the mode (0 codebook, 1 block chaining, 2 output feedback, 3 cipher feedback). Bit 0 selects the direction (1 = decrypt). Bits 4:1 are reserved.
- R2: A start whose byte length is not a multiple of 16, or whose reserved bits are nonzero, gives `done_o` and `fail_o` high together in the cycle after the start. No block is accepted and no core request is made.
- R3: Encrypt core input: codebook uses the data block, block chaining uses data XOR chaining value, and both feedback modes use the chaining value.
- R4: Encrypt output and chaining update: codebook and block chaining emit the core result, and block chaining stores that result. Output feedback stores the core result and emits result XOR data. Cipher feedback emits result XOR data and stores that emitted block.
- R5: Decrypt core input: codebook and block chaining use the data block, and both feedback modes use the chaining value.
- R6: Decrypt output and chaining update: block chaining emits result XOR old chaining value and stores the incoming block. Cipher feedback emits result XOR data and stores the incoming block. Output feedback emits result XOR data and stores the core result. Codebook emits the result.
- R7: A codebook message leaves `iv_o` unchanged in both directions.
- R8: Each block is captured at its input handshake, so changing `in_data_i` afterwards does not change that block's result.
- R9: `core_inv_o` is high with a request only for codebook and block-chaining decryption. `core_req_o` and `core_data_o` hold steady until `core_ack_i`.
- R10: `iv_load_i` loads `iv_i` only while idle and is ignored during a message. After a message, `iv_o` shows the final chaining value, and the next message continues from it.
- R11: `out_data_o` and `out_valid_o` hold steady while `out_ready_i` is low. `done_o` rises with `fail_o` low in the cycle after the last block's output handshake, and at no other block.
- R12: A start with length zero gives `done_o` with `fail_o` low in the next cycle, and no block is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Start strobe (taken while idle) |
| cfg_ctrl_i | input | 7 | Control word: mode, reserved bits, direction |
| cfg_len_i | input | LEN_W | Message length in bytes |
| iv_load_i | input | 1 | Chaining value load strobe |
| iv_i | input | BLK_W | Chaining value to load |
| iv_o | output | BLK_W | Current chaining value |
| in_valid_i | input | 1 | Input block valid |
| in_ready_o | output | 1 | Input block ready |
| in_data_i | input | BLK_W | Input block |
| out_valid_o | output | 1 | Output block valid |
| out_ready_i | input | 1 | Output block ready |
| out_data_o | output | BLK_W | Output block |
| core_req_o | output | 1 | Core request |
| core_inv_o | output | 1 | Core uses the inverse direction and key schedule |
| core_data_o | output | BLK_W | Core input block |
| core_ack_i | input | 1 | Core response valid |
| core_data_i | input | BLK_W | Core result |
| done_o | output | 1 | Message finished (pulse) |
| fail_o | output | 1 | Message rejected (with done_o) |

## Verification
The bench runs every mode in both directions over several blocks. Each ciphertext is decrypted again, which exposes a swapped XOR operand or a wrong chaining source: the plaintext would not come back and the final chaining value would differ from the model. It changes `in_data_i` right after each input handshake and strobes `iv_load_i` in the middle of a message. A design that reads the live input, or that accepts the load while busy, would emit wrong blocks or end with the wrong chaining value. It also sends lengths that are not multiples of 16, nonzero reserved bits and zero length, where a faulty design would start accepting blocks or never raise done. It applies backpressure on the output and stretches the core latency, where a faulty design would change its output or drop its request early.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef enum logic [1:0] {
    MODE_ECB = 2'd0,
    MODE_CBC = 2'd1,
    MODE_OFB = 2'd2,
    MODE_CFB = 2'd3
  } chain_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IN   = 2'd1,
    ST_REQ  = 2'd2,
    ST_OUT  = 2'd3
  } chain_state_e;

  localparam int unsigned CTRL_W    = 7;
  localparam int unsigned MODE_LSB  = 5;
  localparam int unsigned DIR_BIT   = 0;
  localparam int unsigned RSVD_LSB  = 1;
  localparam int unsigned RSVD_W    = 4;
endpackage

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_pkg::*;
#(
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned BLK_LOG2 = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CTRL_W-1:0]        ctrl_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic                     in_valid_i,
  input  logic                     core_ack_i,
  input  logic                     out_ready_i,
  output chain_mode_e              mode_o,
  output logic                     dec_o,
  output logic                     idle_o,
  output logic                     in_ready_o,
  output logic                     cap_o,
  output logic                     core_req_o,
  output logic                     res_en_o,
  output logic                     out_valid_o,
  output logic                     done_o,
  output logic                     fail_o
);
  localparam int unsigned CNT_W = LEN_W - BLK_LOG2;

  chain_state_e      state_q;
  chain_mode_e       mode_q;
  logic              dec_q;
  logic [CNT_W-1:0]  left_q;
  logic              done_q, fail_q;

  logic             reject;
  logic [CNT_W-1:0] nblk;

  assign reject = (|len_i[BLK_LOG2-1:0]) || (|ctrl_i[RSVD_LSB +: RSVD_W]);
  assign nblk   = len_i[LEN_W-1:BLK_LOG2];

  assign idle_o      = (state_q == ST_IDLE);
  assign in_ready_o  = (state_q == ST_IN);
  assign core_req_o  = (state_q == ST_REQ);
  assign out_valid_o = (state_q == ST_OUT);
  assign cap_o       = in_ready_o && in_valid_i;
  assign res_en_o    = core_req_o && core_ack_i;
  assign mode_o      = mode_q;
  assign dec_o       = dec_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_ECB;
      dec_q   <= 1'b0;
      left_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q <= chain_mode_e'(ctrl_i[MODE_LSB +: 2]);
          dec_q  <= ctrl_i[DIR_BIT];
          if (reject) begin
            done_q <= 1'b1;
            fail_q <= 1'b1;
          end else if (nblk == '0) begin
            done_q <= 1'b1;
          end else begin
            left_q  <= nblk;
            state_q <= ST_IN;
          end
        end
        ST_IN:  if (in_valid_i) state_q <= ST_REQ;
        ST_REQ: if (core_ack_i) state_q <= ST_OUT;
        ST_OUT: if (out_ready_i) begin
          if (left_q == CNT_W'(1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            left_q  <= left_q - CNT_W'(1);
            state_q <= ST_IN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && start_i && reject) |=> (done_o && fail_o && idle_o));
  assert_fail_only_with_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);
  assert_zero_len_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && start_i && !reject && nblk == '0) |=> (done_o && !fail_o && idle_o));
  assert_req_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_o && !core_ack_i) |=> core_req_o);
  assert_out_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);
  assert_done_at_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> idle_o);
endmodule

// File: rtl/chain_datapath.sv
module chain_datapath
  import chain_pkg::*;
#(
  parameter int unsigned BLK_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  chain_mode_e       mode_i,
  input  logic              dec_i,
  input  logic              idle_i,
  input  logic              iv_load_i,
  input  logic [BLK_W-1:0]  iv_i,
  input  logic              cap_i,
  input  logic [BLK_W-1:0]  in_data_i,
  input  logic              res_en_i,
  input  logic [BLK_W-1:0]  core_rdata_i,
  output logic [BLK_W-1:0]  core_wdata_o,
  output logic              core_inv_o,
  output logic [BLK_W-1:0]  res_o,
  output logic [BLK_W-1:0]  iv_o
);
  logic [BLK_W-1:0] din_q, iv_q, iv_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) din_q <= '0;
    else if (cap_i) din_q <= in_data_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_ECB: core_wdata_o = din_q;
      MODE_CBC: core_wdata_o = dec_i ? din_q : (din_q ^ iv_q);
      default:  core_wdata_o = iv_q;
    endcase
  end

  assign core_inv_o = dec_i && (mode_i == MODE_ECB || mode_i == MODE_CBC);

  always_comb begin
    unique case (mode_i)
      MODE_ECB: begin
        res_o  = core_rdata_i;
        iv_nxt = iv_q;
      end
      MODE_CBC: begin
        res_o  = dec_i ? (core_rdata_i ^ iv_q) : core_rdata_i;
        iv_nxt = dec_i ? din_q : core_rdata_i;
      end
      MODE_OFB: begin
        res_o  = core_rdata_i ^ din_q;
        iv_nxt = core_rdata_i;
      end
      default: begin
        res_o  = core_rdata_i ^ din_q;
        iv_nxt = dec_i ? din_q : (core_rdata_i ^ din_q);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iv_q <= '0;
    else if (idle_i && iv_load_i) iv_q <= iv_i;
    else if (res_en_i && mode_i != MODE_ECB) iv_q <= iv_nxt;
  end

  assign iv_o = iv_q;

  assert_ecb_keeps_iv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && mode_i == MODE_ECB) |=> $stable(iv_o));
  assert_iv_locked_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !res_en_i) |=> $stable(iv_o));
  assert_capture_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !idle_i && !res_en_i) |=> $stable(core_wdata_o));
endmodule

// File: rtl/chain_outreg.sv
module chain_outreg #(
  parameter int unsigned BLK_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BLK_W-1:0]  d_i,
  input  logic              valid_i,
  input  logic              ready_i,
  output logic [BLK_W-1:0]  q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  assert_out_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_i) |=> $stable(q_o));
endmodule

// File: rtl/blk_chain_unit.sv
module blk_chain_unit
  import chain_pkg::*;
#(
  parameter int unsigned BLK_W = 128,
  parameter int unsigned LEN_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_valid_i,
  input  logic [6:0]         cfg_ctrl_i,
  input  logic [LEN_W-1:0]   cfg_len_i,
  input  logic               iv_load_i,
  input  logic [BLK_W-1:0]   iv_i,
  output logic [BLK_W-1:0]   iv_o,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [BLK_W-1:0]   in_data_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [BLK_W-1:0]   out_data_o,
  output logic               core_req_o,
  output logic               core_inv_o,
  output logic [BLK_W-1:0]   core_data_o,
  input  logic               core_ack_i,
  input  logic [BLK_W-1:0]   core_data_i,
  output logic               done_o,
  output logic               fail_o
);
  localparam int unsigned BLK_LOG2 = $clog2(BLK_W / 8);

  chain_mode_e      mode;
  logic             dec, idle, cap, res_en;
  logic [BLK_W-1:0] res;

  chain_ctrl #(.LEN_W(LEN_W), .BLK_LOG2(BLK_LOG2)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i     (cfg_valid_i),
    .ctrl_i      (cfg_ctrl_i),
    .len_i       (cfg_len_i),
    .in_valid_i,
    .core_ack_i,
    .out_ready_i,
    .mode_o      (mode),
    .dec_o       (dec),
    .idle_o      (idle),
    .in_ready_o,
    .cap_o       (cap),
    .core_req_o,
    .res_en_o    (res_en),
    .out_valid_o,
    .done_o,
    .fail_o
  );

  chain_datapath #(.BLK_W(BLK_W)) u_dp (
    .clk_i, .rst_ni,
    .mode_i       (mode),
    .dec_i        (dec),
    .idle_i       (idle),
    .iv_load_i,
    .iv_i,
    .cap_i        (cap),
    .in_data_i,
    .res_en_i     (res_en),
    .core_rdata_i (core_data_i),
    .core_wdata_o (core_data_o),
    .core_inv_o,
    .res_o        (res),
    .iv_o
  );

  chain_outreg #(.BLK_W(BLK_W)) u_out (
    .clk_i, .rst_ni,
    .load_i  (res_en),
    .d_i     (res),
    .valid_i (out_valid_o),
    .ready_i (out_ready_i),
    .q_o     (out_data_o)
  );
endmodule

// File: tb/sim_blk_chain_unit.sv
module sim_blk_chain_unit;
  localparam int CLK_P = 10;
  localparam int LEN_W = 16;
  localparam logic [127:0] KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic         cfg_valid = 0;
  logic [6:0]   cfg_ctrl = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic         iv_load = 0;
  logic [127:0] iv_in = '0, iv_out;
  logic         in_valid = 0, in_ready;
  logic [127:0] in_data = '0;
  logic         out_valid, out_ready = 0;
  logic [127:0] out_data;
  logic         core_req, core_inv, core_ack = 0;
  logic [127:0] core_wdata, core_rdata = '0;
  logic         done, fail;

  blk_chain_unit #(.BLK_W(128), .LEN_W(LEN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_valid), .cfg_ctrl_i(cfg_ctrl), .cfg_len_i(cfg_len),
    .iv_load_i(iv_load), .iv_i(iv_in), .iv_o(iv_out),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .core_req_o(core_req), .core_inv_o(core_inv), .core_data_o(core_wdata),
    .core_ack_i(core_ack), .core_data_i(core_rdata),
    .done_o(done), .fail_o(fail)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [127:0] m_iv;

  function automatic logic [127:0] core_fn(input logic [127:0] x, input logic inv);
    logic [127:0] y;
    if (!inv) return {x[114:0], x[127:115]} ^ KEY;
    y = x ^ KEY;
    return {y[12:0], y[127:13]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_iv(input logic [127:0] v);
    iv_load = 1; iv_in = v;
    @(negedge clk);
    iv_load = 0; iv_in = '0;
    m_iv = v;
    chk(iv_out == v, "R10 iv load", iv_out, v);
  endtask

  task automatic start_msg(input logic [1:0] mode, input bit dec, input logic [3:0] rsvd, input int len);
    cfg_valid = 1; cfg_ctrl = {mode, rsvd, dec}; cfg_len = LEN_W'(len);
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic run_block(input logic [1:0] mode, input bit dec, input logic [127:0] d,
                           input bit last, input int lat, input bit poke, output logic [127:0] res);
    logic [127:0] ci, co, eo, niv, held;
    logic inv;
    inv = dec && (mode < 2);
    if (!dec) begin
      case (mode)
        0: ci = d; 1: ci = d ^ m_iv; default: ci = m_iv;
      endcase
    end else begin
      ci = (mode < 2) ? d : m_iv;
    end
    co = core_fn(ci, inv);
    niv = m_iv;
    if (!dec) begin
      case (mode)
        0: eo = co;
        1: begin eo = co; niv = co; end
        2: begin eo = co ^ d; niv = co; end
        default: begin eo = co ^ d; niv = eo; end
      endcase
    end else begin
      case (mode)
        0: eo = co;
        1: begin eo = co ^ m_iv; niv = d; end
        2: begin eo = co ^ d; niv = co; end
        default: begin eo = co ^ d; niv = d; end
      endcase
    end
    in_valid = 1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_data = ~d;  // R8: live input changes after capture
    chk(core_req, "R9 request raised", {127'd0, core_req}, 128'd1);
    chk(core_wdata == ci, dec ? "R5 core input" : "R3 core input", core_wdata, ci);
    chk(core_inv == inv, "R9 core direction", {127'd0, core_inv}, {127'd0, inv});
    for (int k = 0; k < lat; k++) begin
      if (poke && k == 0) begin iv_load = 1; iv_in = ~m_iv; end
      @(negedge clk);
      iv_load = 0;
      chk(core_req && core_wdata == ci, "R9 request held", core_wdata, ci);
    end
    core_ack = 1; core_rdata = core_fn(core_wdata, core_inv);
    @(negedge clk);
    core_ack = 0; core_rdata = {4{32'hdead_beef}};
    chk(out_valid, "R11 out valid", {127'd0, out_valid}, 128'd1);
    held = out_data;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == held, "R11 out held", out_data, held);
    end
    chk(out_data == eo, dec ? "R6 decrypt output" : "R4 encrypt output", out_data, eo);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(done == last && !fail, "R11 done timing", {126'd0, done, fail}, {126'd0, last, 1'b0});
    m_iv = niv;
    res = out_data;
  endtask

  task automatic run_msg(input logic [1:0] mode, input bit dec, input int n, input logic [127:0] din[4],
                         output logic [127:0] dout[4], input int lat, input bit poke);
    start_msg(mode, dec, 4'h0, n * 16);
    for (int b = 0; b < n; b++)
      run_block(mode, dec, din[b], b == n - 1, lat + b, poke && b == 1, dout[b]);
    chk(iv_out == m_iv, mode == 0 ? "R7 iv after codebook" : "R10 final iv", iv_out, m_iv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] pt[4], ct[4], rt[4], iv0;
    for (int i = 0; i < 4; i++) pt[i] = {4{32'h1357_9bdf ^ (i * 32'h0101_0101)}} ^ (128'(i) << 64);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!in_ready && !out_valid && !core_req && !done && !fail, "R11 reset state",
        {123'd0, in_ready, out_valid, core_req, done, fail}, 128'd0);
    chk(iv_out == '0, "R10 reset iv", iv_out, 128'd0);

    for (int m = 0; m < 4; m++) begin
      iv0 = 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff ^ (128'(m) << 3);
      load_iv(iv0);
      run_msg(2'(m), 1'b0, 3, pt, ct, 1, m == 1);  // R1 mode m encrypt
      load_iv(iv0);
      run_msg(2'(m), 1'b1, 3, ct, rt, 0, 1'b0);    // R1 mode m decrypt
      for (int b = 0; b < 3; b++)
        chk(rt[b] == pt[b], "R6 round trip", rt[b], pt[b]);
    end

    // R10: chain continues across two messages
    load_iv(128'h5a5a);
    run_msg(2'd1, 1'b0, 2, pt, ct, 0, 1'b0);
    run_msg(2'd3, 1'b0, 1, pt, ct, 2, 1'b0);

    // R2: bad length
    start_msg(2'd1, 1'b0, 4'h0, 40);
    chk(done && fail && !in_ready, "R2 bad length", {125'd0, done, fail, in_ready}, 128'd6);
    @(negedge clk);
    chk(!in_ready && !core_req && !done, "R2 no block", {125'd0, in_ready, core_req, done}, 128'd0);
    // R2: reserved bits
    start_msg(2'd0, 1'b0, 4'h4, 32);
    chk(done && fail && !in_ready, "R2 reserved bits", {125'd0, done, fail, in_ready}, 128'd6);
    // R12: zero length
    @(negedge clk);
    start_msg(2'd2, 1'b1, 4'h0, 0);
    chk(done && !fail && !in_ready, "R12 zero length", {125'd0, done, fail, in_ready}, 128'd4);
    @(negedge clk);
    chk(!done && !in_ready, "R12 idle after", {126'd0, done, in_ready}, 128'd0);
    chk(iv_out == m_iv, "R12 iv untouched", iv_out, m_iv);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule